// File: doc/BRIEF.md
# Uninitialized Register Access Detector

This block watches a bank of sixteen working registers and remembers, one bit per register, whether each has been written since the last reset. Whenever the core uses a register as an address pointer, the block looks up that register's bit. If the register has never been written, it raises a violation strobe toward the reset controller. The reset controller turns that strobe into an illegal-condition reset and records it in its shared illegal-condition status flag.

The highest register, index 15, serves as the stack pointer. It is exempt and always counts as initialized. Every reset marks all other registers as unwritten again. Data reads never pass through this block: only the pointer-use strobe is checked.

Top module: `uninit_ptr_guard`

## Requirements
- R1: While reset is held and right after it, register indices 0 to 14 are uninitialized, and the violation output is 0 during reset.
- R2: A write to register index k marks k initialized. A later pointer use of k produces no violation.
- R3: Index 15 is always initialized. A pointer use of 15 never causes a violation, whether or not 15 was written.
- R4: A pointer use of an uninitialized register raises `viol_o` for exactly the one cycle after the access. Back-to-back offending accesses give one pulse each.
- R5: When a write and a pointer use name the same register in one cycle, the pointer use is judged on the state before the write.
- R6: With `ptr_en_i` low, no violation is raised, whatever `ptr_idx_i` holds. This is the case of plain data reads.
- R7: Asserting reset again returns registers 0 to 14 to the uninitialized state, even after they have been written.
- R8: A write to one register leaves the state of every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Index of the register being written |
| ptr_en_i | input | 1 | Address-pointer use strobe |
| ptr_idx_i | input | 4 | Index of the register used as a pointer |
| viol_o | output | 1 | One-cycle violation strobe to the reset controller |

## Verification
A register write and a pointer use can land in the same cycle, and they can target the same register. The bench provokes this by driving both strobes with the same index on a register that was never written. It expects a violation in the next cycle, because the lookup must see the state before the write. It then repeats the pointer use alone and expects no violation, which shows the write did take effect.

// File: rtl/upg_pkg.sv
package upg_pkg;
  localparam int unsigned UPG_DEF_REGS   = 16;
  localparam int unsigned UPG_DEF_EXEMPT = 15;
  localparam int unsigned UPG_SYNC_DEPTH = 2;
endpackage

// File: rtl/upg_rst_sync.sv
module upg_rst_sync #(
  parameter int unsigned DEPTH = upg_pkg::UPG_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[DEPTH-1];
endmodule

// File: rtl/upg_wr_decode.sv
module upg_wr_decode #(
  parameter int unsigned NUM_REGS = upg_pkg::UPG_DEF_REGS,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  output logic [NUM_REGS-1:0] set_vec
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign set_vec[i] = wr_en && (wr_idx == IDX_W'(i));
  end
endmodule

// File: rtl/upg_valid_array.sv
module upg_valid_array #(
  parameter int unsigned NUM_REGS  = upg_pkg::UPG_DEF_REGS,
  parameter int unsigned EXEMPT_IX = upg_pkg::UPG_DEF_EXEMPT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_vec,
  output logic [NUM_REGS-1:0] valid_vec
);
  logic [NUM_REGS-1:0] valid_q;
  logic [NUM_REGS-1:0] valid_d;
  logic [NUM_REGS-1:0] load_en;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
    localparam logic RST_VAL = (i == EXEMPT_IX);

    always_comb begin
      load_en[i] = set_vec[i] && !valid_q[i];
      valid_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q[i] <= RST_VAL;
      else if (load_en[i]) valid_q[i] <= valid_d[i];
    end
  end

  assign valid_vec = valid_q;

  // R2: a write leaves its target marked initialized
  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((valid_vec & $past(set_vec)) == $past(set_vec)));

  // R8: only written registers may change state
  p_no_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_vec & ~$past(valid_vec)) & ~$past(set_vec)) == '0);

  // R7: outside reset no bit ever falls back to uninitialized
  p_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_vec & $past(valid_vec)) == $past(valid_vec)));

  // R3: the exempt register reads as initialized
  p_exempt_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_vec[EXEMPT_IX]);
endmodule

// File: rtl/upg_ptr_check.sv
module upg_ptr_check #(
  parameter int unsigned NUM_REGS  = upg_pkg::UPG_DEF_REGS,
  parameter int unsigned EXEMPT_IX = upg_pkg::UPG_DEF_EXEMPT,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ptr_en,
  input  logic [IDX_W-1:0]    ptr_idx,
  input  logic [NUM_REGS-1:0] valid_vec,
  output logic                viol
);
  logic sel_valid;
  logic hit_d;
  logic viol_q;

  always_comb begin
    sel_valid = valid_vec[ptr_idx];
    hit_d     = ptr_en && !sel_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= hit_d;
  end

  assign viol = viol_q;

  // R6: no pointer strobe, no violation
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_en |=> !viol);

  // R3: exempt register never flags
  p_exempt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && ptr_idx == IDX_W'(EXEMPT_IX)) |=> !viol);

  // R4: unwritten pointer flags in the next cycle
  p_flag_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && !valid_vec[ptr_idx]) |=> viol);

  // R2: written pointer stays clean
  p_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && valid_vec[ptr_idx]) |=> !viol);
endmodule

// File: rtl/uninit_ptr_guard.sv
module uninit_ptr_guard #(
  parameter int unsigned NUM_REGS  = upg_pkg::UPG_DEF_REGS,
  parameter int unsigned EXEMPT_IX = upg_pkg::UPG_DEF_EXEMPT,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             ptr_en_i,
  input  logic [IDX_W-1:0] ptr_idx_i,
  output logic             viol_o
);
  logic                rst_n_sync;
  logic [NUM_REGS-1:0] set_vec;
  logic [NUM_REGS-1:0] valid_vec;

  upg_rst_sync #(.DEPTH(upg_pkg::UPG_SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  upg_wr_decode #(.NUM_REGS(NUM_REGS)) u_wr_decode (
    .wr_en   (wr_en_i),
    .wr_idx  (wr_idx_i),
    .set_vec (set_vec)
  );

  upg_valid_array #(.NUM_REGS(NUM_REGS), .EXEMPT_IX(EXEMPT_IX)) u_valid (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .set_vec   (set_vec),
    .valid_vec (valid_vec)
  );

  upg_ptr_check #(.NUM_REGS(NUM_REGS), .EXEMPT_IX(EXEMPT_IX)) u_ptr_check (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .ptr_en    (ptr_en_i),
    .ptr_idx   (ptr_idx_i),
    .valid_vec (valid_vec),
    .viol      (viol_o)
  );

  // R5: a same-cycle write does not hide an unwritten pointer
  p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en_i && ptr_en_i && wr_idx_i == ptr_idx_i && !valid_vec[ptr_idx_i])
    |=> viol_o);

  // R4: the strobe never stretches without a fresh offending access
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (viol_o && !ptr_en_i) |=> !viol_o);
endmodule

// File: tb/uninit_ptr_guard_bench.sv
module uninit_ptr_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic       ptr_en = 1'b0;
  logic [3:0] ptr_idx = '0;
  logic       viol;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] mvalid;
  int          n_checks = 0;
  int          n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uninit_ptr_guard u_uninit_ptr_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .ptr_en_i  (ptr_en),
    .ptr_idx_i (ptr_idx),
    .viol_o    (viol)
  );

  task automatic drive(input logic we, input int wi, input logic pe,
                       input int pi, input string tag);
    exp_t it;
    @(negedge clk);
    wr_en   = we;
    wr_idx  = wi[3:0];
    ptr_en  = pe;
    ptr_idx = pi[3:0];
    it.exp  = pe && !mvalid[pi];
    it.tag  = tag;
    sb_q.push_back(it);
    if (we) mvalid[wi] = 1'b1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) drive(1'b0, 0, 1'b0, 0, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    wr_en = 1'b0; ptr_en = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (viol !== 1'b0) begin
      n_fails++;
      $display("FAIL %s: viol during reset actual=%b expected=0", tag, viol);
    end
    mvalid = 16'h8000;
    rst_n  = 1'b1;
    idle(3, tag);
  endtask

  // monitor: compare one scoreboard item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (viol !== it.exp) begin
          n_fails++;
          $display("FAIL %s: viol actual=%b expected=%b", it.tag, viol, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    mvalid = 16'h8000;
    do_reset("R1");
    // R1: every non-exempt index flags after reset
    for (int r = 0; r < 15; r++) drive(1'b0, 0, 1'b1, r, "R1");
    // R3: exempt index is clean without a write
    drive(1'b0, 0, 1'b1, 15, "R3");
    idle(1, "R4");
    // R2 then R8: write 3, use 3 clean, use 4 still flags
    drive(1'b1, 3, 1'b0, 0, "R2");
    drive(1'b0, 0, 1'b1, 3, "R2");
    drive(1'b0, 0, 1'b1, 4, "R8");
    idle(1, "R4");
    // R6: pointer strobe low with an unwritten index
    drive(1'b0, 0, 1'b0, 5, "R6");
    drive(1'b1, 6, 1'b0, 5, "R6");
    // R5: same-cycle write and use of 7, then clean use
    drive(1'b1, 7, 1'b1, 7, "R5");
    drive(1'b0, 0, 1'b1, 7, "R5");
    // R4: back-to-back pulses, then a single clear cycle
    drive(1'b0, 0, 1'b1, 8, "R4");
    drive(1'b0, 0, 1'b1, 9, "R4");
    idle(2, "R4");
    // R3: write to 15 keeps it clean
    drive(1'b1, 15, 1'b0, 0, "R3");
    drive(1'b0, 0, 1'b1, 15, "R3");
    // write everything, then R7: reset re-invalidates
    for (int r = 0; r < 16; r++) drive(1'b1, r, 1'b0, 0, "R2");
    drive(1'b0, 0, 1'b1, 10, "R2");
    idle(1, "R2");
    do_reset("R7");
    drive(1'b0, 0, 1'b1, 3, "R7");
    drive(1'b0, 0, 1'b1, 10, "R7");
    drive(1'b0, 0, 1'b1, 15, "R3");
    idle(3, "R4");
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule